// File: doc/BRIEF.md
# ISA Clock Divider and I/O Recovery Timer

This block derives the slow expansion-bus clock from the PCI clock and keeps the bus idle for a minimum time between back-to-back I/O commands. A configuration byte, loaded through a write strobe, picks a divide ratio of 4 or 3 and holds two independent recovery settings, one for 8-bit and one for 16-bit I/O. The ISA command sequencer pulses `io_done` when an I/O command ends and gives the width of that cycle on `io_wide`. The block then raises `io_busy`, which keeps the sequencer from starting the next I/O command until the recovery window has passed.

Every recovery window is a fixed 3.5 ISA clocks plus a programmable number of whole ISA clocks. The timer counts in half ISA clocks and charges each half clock as two PCI clocks. At divide-by-4 that is exact. At divide-by-3 it rounds up, so the window is never shorter than required. A new divide ratio only takes effect at the start of an ISA clock period, which keeps short pulses off the bus clock.

Top module: `isa_rcv_timer`

## Requirements
- R1: The configuration byte resets to 0x4D and is replaced by `cfg_din` on a cycle with `cfg_we` high. With that value the bus clock divides by 4, and both 8-bit and 16-bit recovery last 18 PCI clocks.
- R2: With configuration bit 7 at 0, `isa_clk` is high for 2 PCI clocks and low for 2. `isa_clk_en` is high for one PCI clock, only in the cycle where `isa_clk` has just risen.
- R3: With configuration bit 7 at 1, `isa_clk` has a period of 3 PCI clocks: high for 2 and low for 1.
- R4: A change of configuration bit 7 takes effect only when a new `isa_clk` period starts. No high phase is ever shorter than 2 PCI clocks and no low phase is shorter than 1.
- R5: `io_busy` is high from the cycle after an `io_done` pulse and stays high for exactly 2 × (7 + 2 × extra) PCI clocks, where extra is the number of extra ISA clocks selected for the width given on `io_wide` (0 = 8-bit, 1 = 16-bit). While idle with no `io_done`, `io_busy` stays low.
- R6: When configuration bit 6 is 0, 8-bit recovery is 14 PCI clocks (3.5 ISA clocks), whatever bits 5:3 hold.
- R7: When configuration bit 6 is 1, bits 5:3 add 0 to 7 ISA clocks to 8-bit recovery, giving 14 + 4 × field PCI clocks (at most 42).
- R8: When configuration bit 2 is 0, 16-bit recovery is 14 PCI clocks, whatever bits 1:0 hold.
- R9: When configuration bit 2 is 1, bits 1:0 add ISA clocks to 16-bit recovery: 01 adds 1, 10 adds 2, 11 adds 3 and 00 adds 4 (30 PCI clocks). The 8-bit fields have no effect on a 16-bit window.
- R10: At divide-by-3 a half ISA clock still counts as 2 PCI clocks, so recovery lengths in PCI clocks match the divide-by-4 values.
- R11: While `rst` is high, `io_busy`, `isa_clk` and `isa_clk_en` are 0. In the first cycle after reset `isa_clk` rises and `isa_clk_en` pulses, so the clock phase restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load strobe for the configuration byte |
| cfg_din | input | 8 | Configuration byte: bit 7 ratio, bit 6/5:3 8-bit recovery, bit 2/1:0 16-bit recovery |
| io_done | input | 1 | One-cycle pulse at the end of an I/O command |
| io_wide | input | 1 | Width of the ending command: 0 = 8-bit, 1 = 16-bit |
| isa_clk | output | 1 | Divided ISA bus clock |
| isa_clk_en | output | 1 | One-cycle pulse in the cycle `isa_clk` rises |
| io_busy | output | 1 | High while recovery time is still running |

## Verification
The bench changes the divide ratio at each of the four phase offsets and measures every high and low run of the bus clock. A divider that switched mid-period would produce a runt phase, and one that never switched would keep the old period. Recovery windows are measured at the 0, 3 and 7 ends of the 8-bit field and at every 16-bit code. A decoder that treated 16-bit code 00 as zero would give 14 clocks instead of 30, and one that mixed up the two widths would give 42 where 30 is expected. A reset in the middle of a window and the recovery values read back after reset show whether a design clears its count and whether its configuration default is wrong.

// File: rtl/isa_rcv_pkg.sv
package isa_rcv_pkg;

    // Configuration byte layout. Software writes it, so the bit positions are fixed.
    typedef struct packed {
        logic       div3;      // 1: divide by 3, 0: divide by 4
        logic       ext8_en;   // use the 8-bit extra field
        logic [2:0] ext8;      // extra ISA clocks, 8-bit I/O
        logic       ext16_en;  // use the 16-bit extra field
        logic [1:0] ext16;     // extra ISA clocks, 16-bit I/O (00 = 4)
    } rcv_cfg_t;

    localparam int unsigned BASE_HALVES     = 7;  // 3.5 ISA clocks
    localparam int unsigned MAX_EXTRA       = 7;
    localparam int unsigned EXT16_ZERO_CLKS = 4;

    // Extra whole ISA clocks selected for one command width
    function automatic int unsigned extra_clks(rcv_cfg_t c, logic wide);
        int unsigned e;
        e = 0;
        if (wide) begin
            if (c.ext16_en)
                e = (c.ext16 == 2'b00) ? EXT16_ZERO_CLKS : int'(c.ext16);
        end else if (c.ext8_en) begin
            e = int'(c.ext8);
        end
        return e;
    endfunction

    // PCI clocks charged per half ISA clock, rounded up
    function automatic int unsigned half_pci(int unsigned div);
        return (div + 1) / 2;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/isa_rcv_cfg.sv
module isa_rcv_cfg
    import isa_rcv_pkg::*;
#(
    parameter logic [7:0] CFG_RST = 8'h4D
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] din,
    output rcv_cfg_t   cfg
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= rcv_cfg_t'(CFG_RST);
        else if (we)
            cfg <= rcv_cfg_t'(din);
    end

endmodule

// File: rtl/isa_clk_div.sv
module isa_clk_div
    import isa_rcv_pkg::*;
#(
    parameter int unsigned DIV_SLOW = 4,
    parameter int unsigned DIV_FAST = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_fast,
    output logic isa_clk,
    output logic isa_en,
    output logic fast_act
);

    localparam int unsigned PH_W = $clog2(max_u(DIV_SLOW, DIV_FAST));
    localparam logic [PH_W-1:0] LAST_S = PH_W'(DIV_SLOW - 1);
    localparam logic [PH_W-1:0] LAST_F = PH_W'(DIV_FAST - 1);
    localparam logic [PH_W-1:0] HI_S   = PH_W'(half_pci(DIV_SLOW));
    localparam logic [PH_W-1:0] HI_F   = PH_W'(half_pci(DIV_FAST));

    logic [PH_W-1:0] ph_q, ph_n;
    logic            fast_q, fast_n, wrap;

    always_comb begin
        wrap   = (ph_q == (fast_q ? LAST_F : LAST_S));
        // The ratio is only re-sampled as a new period begins
        fast_n = wrap ? sel_fast : fast_q;
        ph_n   = wrap ? '0 : ph_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= LAST_S;
            fast_q  <= 1'b0;
            isa_clk <= 1'b0;
            isa_en  <= 1'b0;
        end else begin
            ph_q    <= ph_n;
            fast_q  <= fast_n;
            isa_clk <= (ph_n < (fast_n ? HI_F : HI_S));
            isa_en  <= wrap;
        end
    end

    assign fast_act = fast_q;

endmodule

// File: rtl/isa_rcv_calc.sv
module isa_rcv_calc
    import isa_rcv_pkg::*;
#(
    parameter int unsigned DIV_SLOW = 4,
    parameter int unsigned DIV_FAST = 3,
    parameter int unsigned CNT_W    = 6
) (
    input  rcv_cfg_t         cfg,
    input  logic             wide,
    input  logic             fast,
    output logic [CNT_W-1:0] cycles
);

    localparam int unsigned HS = half_pci(DIV_SLOW);
    localparam int unsigned HF = half_pci(DIV_FAST);

    int unsigned halves;

    always_comb begin
        halves = BASE_HALVES + 2 * extra_clks(cfg, wide);
        cycles = CNT_W'(halves * (fast ? HF : HS));
    end

endmodule

// File: rtl/isa_rcv_cnt.sv
module isa_rcv_cnt #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/isa_rcv_timer.sv
module isa_rcv_timer
    import isa_rcv_pkg::*;
#(
    parameter int unsigned DIV_SLOW = 4,
    parameter int unsigned DIV_FAST = 3,
    parameter logic [7:0]  CFG_RST  = 8'h4D
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [7:0] cfg_din,
    input  logic       io_done,
    input  logic       io_wide,
    output logic       isa_clk,
    output logic       isa_clk_en,
    output logic       io_busy
);

    localparam int unsigned REC_MAX = (BASE_HALVES + 2 * MAX_EXTRA) *
                                      max_u(half_pci(DIV_SLOW), half_pci(DIV_FAST));
    localparam int unsigned CNT_W   = $clog2(REC_MAX + 1);

    rcv_cfg_t         cfg;
    logic             fast_act;
    logic [CNT_W-1:0] rec_cycles;

    isa_rcv_cfg #(.CFG_RST(CFG_RST)) cfg_i (
        .clk (clk),
        .rst (rst),
        .we  (cfg_we),
        .din (cfg_din),
        .cfg (cfg)
    );

    isa_clk_div #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) div_i (
        .clk      (clk),
        .rst      (rst),
        .sel_fast (cfg.div3),
        .isa_clk  (isa_clk),
        .isa_en   (isa_clk_en),
        .fast_act (fast_act)
    );

    isa_rcv_calc #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .CNT_W(CNT_W)) calc_i (
        .cfg    (cfg),
        .wide   (io_wide),
        .fast   (fast_act),
        .cycles (rec_cycles)
    );

    isa_rcv_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .load     (io_done),
        .load_val (rec_cycles),
        .busy     (io_busy)
    );

endmodule

// File: rtl/isa_rcv_timer_chk.sv
module isa_rcv_timer_chk #(
    parameter int unsigned MAX_CYC = 42,
    parameter int unsigned RUN_W   = 8
) (
    input logic clk,
    input logic rst,
    input logic io_done,
    input logic isa_clk,
    input logic isa_clk_en,
    input logic io_busy
);

    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)
            run_len <= '0;
        else if (io_done)
            run_len <= RUN_W'(1);
        else if (io_busy)
            run_len <= run_len + 1'b1;
        else
            run_len <= '0;
    end

    p_en_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
        isa_clk_en |-> (isa_clk && !$past(isa_clk)));

    p_no_runt_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(isa_clk) |-> $past(isa_clk, 2));

    p_busy_start_r5: assert property (@(posedge clk) disable iff (rst)
        io_done |=> io_busy);

    p_busy_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!io_busy && !io_done) |=> !io_busy);

    p_busy_bound_r7: assert property (@(posedge clk) disable iff (rst)
        io_busy |-> (run_len <= RUN_W'(MAX_CYC)));

    p_reset_r11: assert property (@(posedge clk)
        rst |=> (!io_busy && !isa_clk && !isa_clk_en));

endmodule

bind isa_rcv_timer isa_rcv_timer_chk #(.MAX_CYC(REC_MAX)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .io_done    (io_done),
    .isa_clk    (isa_clk),
    .isa_clk_en (isa_clk_en),
    .io_busy    (io_busy)
);

// File: tb/isa_rcv_timer_tb_top.sv
module isa_rcv_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_din = 8'h00;
    logic       io_done = 1'b0;
    logic       io_wide = 1'b0;
    logic       isa_clk, isa_clk_en, io_busy;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    isa_rcv_timer dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_din    (cfg_din),
        .io_done    (io_done),
        .io_wide    (io_wide),
        .isa_clk    (isa_clk),
        .isa_clk_en (isa_clk_en),
        .io_busy    (io_busy)
    );

    task automatic check(input bit ok, input string req, input int act,
                         input int exp, input string what);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Scoreboard: expected busy lengths
    int    exp_q[$];
    string tag_q[$];
    int    b_run = 0;
    int    b_exp;
    string b_tag;

    always @(negedge clk) begin
        if (rst) begin
            b_run = 0;
        end else if (io_busy) begin
            b_run++;
        end else if (b_run > 0) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", b_run, 0, "unexpected busy window");
            end else begin
                b_exp = exp_q.pop_front();
                b_tag = tag_q.pop_front();
                check(b_run == b_exp, b_tag, b_run, b_exp, "busy length");
            end
            b_run = 0;
        end
    end

    // Clock shape monitor
    bit prev_clk = 1'b0;
    bit lo_valid = 1'b0;
    int hi_run = 0;
    int lo_run = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_clk = 1'b0;
            lo_valid = 1'b0;
            hi_run   = 0;
            lo_run   = 0;
        end else begin
            if (isa_clk_en)
                check(isa_clk && !prev_clk, "R2", int'(isa_clk), 1, "enable away from rising edge");
            if (isa_clk) begin
                if (!prev_clk && lo_valid)
                    check(lo_run == 1 || lo_run == 2, "R4", lo_run, 2, "low phase length");
                lo_run   = 0;
                lo_valid = 1'b0;
                hi_run++;
            end else begin
                if (prev_clk) begin
                    check(hi_run == 2, "R4", hi_run, 2, "high phase length");
                    hi_run   = 0;
                    lo_valid = 1'b1;
                end
                lo_run++;
            end
            prev_clk = isa_clk;
        end
    end

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we  = 1'b1;
        cfg_din = v;
        @(negedge clk);
        cfg_we  = 1'b0;
    endtask

    task automatic run_io(input bit wide, input int exp, input string tag);
        while (io_busy) @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        io_done = 1'b1;
        io_wide = wide;
        @(negedge clk);
        io_done = 1'b0;
        check(io_busy == 1'b1, "R5", int'(io_busy), 1, "busy one cycle after done");
        for (int g = 0; g < 200 && exp_q.size() != 0; g++) @(negedge clk);
    endtask

    task automatic measure_period(output int p);
        do @(negedge clk); while (!isa_clk_en);
        p = 0;
        do begin
            @(negedge clk);
            p++;
        end while (!isa_clk_en);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int per;

        // R11: reset state and phase restart
        repeat (4) @(negedge clk);
        check(io_busy == 1'b0, "R11", int'(io_busy), 0, "busy in reset");
        check(isa_clk == 1'b0, "R11", int'(isa_clk), 0, "isa_clk in reset");
        check(isa_clk_en == 1'b0, "R11", int'(isa_clk_en), 0, "enable in reset");
        rst = 1'b0;
        @(negedge clk);
        check(isa_clk == 1'b1 && isa_clk_en == 1'b1, "R11",
              int'({isa_clk, isa_clk_en}), 3, "clock rises after reset");

        // R1 / R2: default configuration 0x4D
        measure_period(per);
        check(per == 4, "R2", per, 4, "divide-by-4 period");
        run_io(1'b0, 18, "R1");
        run_io(1'b1, 18, "R1");

        // R6: 8-bit extra disabled, field ignored
        write_cfg(8'h00);
        run_io(1'b0, 14, "R6");
        write_cfg(8'h38);
        run_io(1'b0, 14, "R6");

        // R7: 8-bit extra enabled
        write_cfg(8'h40);
        run_io(1'b0, 14, "R7");
        write_cfg(8'h58);
        run_io(1'b0, 26, "R7");
        write_cfg(8'h78);
        run_io(1'b0, 42, "R7");

        // R8: 16-bit extra disabled
        write_cfg(8'h03);
        run_io(1'b1, 14, "R8");

        // R9: 16-bit codes, 00 is the largest
        write_cfg(8'h04);
        run_io(1'b1, 30, "R9");
        write_cfg(8'h05);
        run_io(1'b1, 18, "R9");
        write_cfg(8'h06);
        run_io(1'b1, 22, "R9");
        write_cfg(8'h07);
        run_io(1'b1, 26, "R9");
        write_cfg(8'h7C);
        run_io(1'b1, 30, "R9");
        run_io(1'b0, 42, "R9");

        // R3: divide by 3
        write_cfg(8'hCD);
        measure_period(per);
        check(per == 3, "R3", per, 3, "divide-by-3 period");
        measure_period(per);
        check(per == 3, "R3", per, 3, "divide-by-3 period repeat");

        // R10: recovery unchanged at divide by 3
        run_io(1'b0, 18, "R10");
        write_cfg(8'h80);
        run_io(1'b0, 14, "R10");
        run_io(1'b1, 14, "R10");

        // R4: ratio changes at every phase offset
        for (int off = 0; off < 4; off++) begin
            repeat (off) @(negedge clk);
            write_cfg(8'h00);
            measure_period(per);
            measure_period(per);
            check(per == 4, "R4", per, 4, "period after switch to /4");
            repeat (off) @(negedge clk);
            write_cfg(8'h80);
            measure_period(per);
            measure_period(per);
            check(per == 3, "R4", per, 3, "period after switch to /3");
        end

        // R11: reset in the middle of a window, then R1 defaults return
        write_cfg(8'h78);
        @(negedge clk);
        io_done = 1'b1;
        io_wide = 1'b0;
        @(negedge clk);
        io_done = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(io_busy == 1'b0, "R11", int'(io_busy), 0, "busy cleared by reset");
        check(isa_clk == 1'b0, "R11", int'(isa_clk), 0, "clock low in reset");
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(isa_clk_en == 1'b1, "R11", int'(isa_clk_en), 1, "phase restart");
        measure_period(per);
        check(per == 4, "R1", per, 4, "default ratio after reset");
        run_io(1'b0, 18, "R1");
        run_io(1'b1, 18, "R1");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R5", exp_q.size(), 0, "pending windows");
        finish_run();
    end

endmodule